// File: doc/BRIEF.md
# Trap and Interrupt Control Override

This block sits between the instruction decoder and the datapath of a simple 32-bit RISC core. Each cycle it looks at the current program counter, the opcode of the instruction being executed, the external interrupt request and the reset line. When none of them calls for a trap, the decoder's control signals pass through unchanged. When one does, the block takes over the next-PC select, the register-file write controls and the memory write enable. The core then jumps to a fixed handler address and keeps the return address.

The processor's privilege level is held in bit 31 of the PC. A 1 in that bit means supervisor mode, and interrupt requests are held off while it is set. An opcode whose bit in a 64-entry implemented-opcode mask is clear is trapped as an illegal instruction in either mode. The trap redirects the PC to a handler vector with bit 31 set and writes PC+4 into register 30. Any store that was in flight is cancelled. The override is combinational, so the PC register outside the block loads the handler address on the next clock edge.

Top module: `trap_ctl_top`

## Requirements
- R1: While `rst` is 1, `pc_sel` is 4, `vec_addr` is 0x80000000, `rf_we` is 0, `mem_we` is 0 and `trap_taken` is 1, whatever the other inputs are.
- R2: When reset is low and `impl_mask[opcode]` is 0, `pc_sel` is 4 and `vec_addr` is 0x80000004. The register write goes to address 30 with `rf_we` 1 and `rf_wd_sel` 0 (the PC+4 source). This holds in user and in supervisor mode.
- R3: When reset is low, the opcode is implemented, `irq` is 1 and `pc[31]` is 0, the outputs match R2 except that `vec_addr` is 0x80000008.
- R4: An `irq` while `pc[31]` is 1 is ignored. Every output then equals the no-trap pass-through of R7.
- R5: Priority is reset, then illegal opcode, then interrupt. An illegal opcode together with a user-mode `irq` selects 0x80000004.
- R6: `ret_addr` is `{pc[31], pc[30:0] + 4}`. The low 31 bits wrap and the mode bit is kept.
- R7: With no trap, `pc_sel`, `rf_wd_sel`, `rf_waddr` and `mem_we` equal the decoder inputs, `vec_addr` is 0 and `trap_taken` is 0.
- R8: `mem_we` is 0 in every cycle in which a trap is taken.
- R9: `rf_we` is never 1 while `rf_waddr` is 31.
- R10: Every vector driven while `trap_taken` is 1 has bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; itself a trap event |
| pc | input | 32 | Current PC; bit 31 is the supervisor bit |
| opcode | input | 6 | Instruction bits 31:26 |
| irq | input | 1 | External interrupt request |
| impl_mask | input | 64 | Bit n set means opcode n is implemented in hardware |
| dec_pc_sel | input | 3 | Decoder next-PC select |
| dec_wd_sel | input | 2 | Decoder write-data select (0 = PC+4) |
| dec_waddr | input | 5 | Decoder write register address |
| dec_rf_we | input | 1 | Decoder register write enable |
| dec_mem_we | input | 1 | Decoder memory write enable |
| pc_sel | output | 3 | Final next-PC select; 4 selects the vector |
| vec_addr | output | 32 | Handler address, 0 when no trap |
| ret_addr | output | 32 | Return address to save (PC+4, mode bit kept) |
| rf_wd_sel | output | 2 | Final write-data select |
| rf_waddr | output | 5 | Final write register address |
| rf_we | output | 1 | Final register write enable |
| mem_we | output | 1 | Final memory write enable |
| trap_taken | output | 1 | A trap is being taken this cycle |

## Verification
Two traps can be requested in the same cycle. The bench provokes this by presenting a user-mode PC, an asserted `irq` and an opcode whose mask bit is clear, often with a store decoded at the same time. The outcome is judged against the priority order: the illegal-opcode vector must win and the store must be cancelled. The same collision with reset high is checked to confirm that no XP write happens. Random cycles mix these cases with supervisor-mode interrupts, writes to register 31 and PCs next to the 31-bit wrap.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;
    localparam int XLEN     = 32;
    localparam int OPW      = 6;
    localparam int RW       = 5;
    localparam int XP_IDX   = 30;
    localparam int ZERO_IDX = 31;
    localparam logic [XLEN-1:0] VEC_BASE = 32'h8000_0000;

    typedef enum logic [2:0] {
        PCS_INC = 3'd0, PCS_BR = 3'd1, PCS_JMP = 3'd2, PCS_ILL = 3'd3, PCS_VEC = 3'd4
    } pcsel_e;

    localparam logic [1:0] WD_PC4 = 2'd0;

    // Encoding doubles as the vector slot index.
    typedef enum logic [1:0] {
        EV_RESET = 2'd0, EV_ILLOP = 2'd1, EV_IRQ = 2'd2, EV_NONE = 2'd3
    } event_e;

    typedef struct packed {
        logic [2:0]    pc_sel;
        logic [1:0]    wd_sel;
        logic [RW-1:0] wa;
        logic          rf_we;
        logic          mem_we;
    } ctl_t;

    function automatic logic [XLEN-1:0] vec_of(event_e e);
        return VEC_BASE | {{(XLEN-4){1'b0}}, e, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] ret_of(logic [XLEN-1:0] p);
        return {p[XLEN-1], p[XLEN-2:0] + {{(XLEN-4){1'b0}}, 3'd4}};
    endfunction
endpackage

// File: rtl/trap_detect.sv
module trap_detect
    import trap_ctl_pkg::*;
#(
    parameter int OP_W = OPW,
    localparam int NOPC = 1 << OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup,
    input  logic            irq,
    input  logic [OP_W-1:0] opcode,
    input  logic [NOPC-1:0] impl_mask,
    output event_e          ev
);
    logic illegal;
    assign illegal = ~impl_mask[opcode];

    always_comb begin
        if (rst)                ev = EV_RESET;
        else if (illegal)       ev = EV_ILLOP;
        else if (irq && !sup)   ev = EV_IRQ;
        else                    ev = EV_NONE;
    end

    // R2 / R5: a clear mask bit wins over an interrupt
    p_illop_first_r5: assert property (@(posedge clk) disable iff (rst)
        (!impl_mask[opcode] && irq && !sup) |-> ev == EV_ILLOP);
    // R4: supervisor mode holds interrupts off
    p_irq_held_r4: assert property (@(posedge clk) disable iff (rst)
        (sup && impl_mask[opcode]) |-> ev == EV_NONE);
endmodule

// File: rtl/trap_override.sv
module trap_override
    import trap_ctl_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  event_e        ev,
    input  ctl_t          dec,
    output ctl_t          ctl,
    output logic [AW-1:0] vec,
    output logic          taken
);
    always_comb begin
        ctl   = dec;
        taken = (ev != EV_NONE);
        vec   = '0;
        if (taken) begin
            vec        = vec_of(ev);
            ctl.pc_sel = PCS_VEC;
            ctl.wd_sel = WD_PC4;
            ctl.wa     = RW'(XP_IDX);
            ctl.rf_we  = (ev != EV_RESET);
            ctl.mem_we = 1'b0;
        end
        if (ctl.wa == RW'(ZERO_IDX)) ctl.rf_we = 1'b0;
    end

    // R2 / R3: a non-reset trap saves into XP
    p_xp_save_r2: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_ILLOP || ev == EV_IRQ) |-> (ctl.wa == RW'(XP_IDX) && ctl.rf_we && ctl.wd_sel == WD_PC4));
    // R7: pass-through of the decoder's store
    p_pass_store_r7: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_NONE) |-> (ctl.mem_we == dec.mem_we && vec == '0));
endmodule

// File: rtl/trap_ctl_top.sv
module trap_ctl_top
    import trap_ctl_pkg::*;
#(
    parameter int AW   = XLEN,
    parameter int OP_W = OPW,
    localparam int NOPC = 1 << OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   pc,
    input  logic [OP_W-1:0] opcode,
    input  logic            irq,
    input  logic [NOPC-1:0] impl_mask,
    input  logic [2:0]      dec_pc_sel,
    input  logic [1:0]      dec_wd_sel,
    input  logic [RW-1:0]   dec_waddr,
    input  logic            dec_rf_we,
    input  logic            dec_mem_we,
    output logic [2:0]      pc_sel,
    output logic [AW-1:0]   vec_addr,
    output logic [AW-1:0]   ret_addr,
    output logic [1:0]      rf_wd_sel,
    output logic [RW-1:0]   rf_waddr,
    output logic            rf_we,
    output logic            mem_we,
    output logic            trap_taken
);
    event_e ev;
    ctl_t   dec_c, out_c;

    assign dec_c = '{pc_sel: dec_pc_sel, wd_sel: dec_wd_sel, wa: dec_waddr,
                     rf_we: dec_rf_we, mem_we: dec_mem_we};

    trap_detect #(.OP_W(OP_W)) i_detect (
        .clk(clk), .rst(rst), .sup(pc[AW-1]), .irq(irq),
        .opcode(opcode), .impl_mask(impl_mask), .ev(ev)
    );

    trap_override #(.AW(AW)) i_override (
        .clk(clk), .rst(rst), .ev(ev), .dec(dec_c),
        .ctl(out_c), .vec(vec_addr), .taken(trap_taken)
    );

    assign pc_sel    = out_c.pc_sel;
    assign rf_wd_sel = out_c.wd_sel;
    assign rf_waddr  = out_c.wa;
    assign rf_we     = out_c.rf_we;
    assign mem_we    = out_c.mem_we;
    assign ret_addr  = ret_of(pc);

    p_reset_vec_r1: assert property (@(posedge clk)
        rst |-> (pc_sel == 3'd4 && vec_addr == 32'h8000_0000 && !rf_we && !mem_we));
    p_store_abort_r8: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> !mem_we);
    p_no_zero_write_r9: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> rf_waddr != 5'd31);
    p_vec_super_r10: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> vec_addr[AW-1]);
    p_ret_mode_r6: assert property (@(posedge clk) disable iff (rst)
        ret_addr[AW-1] == pc[AW-1]);
endmodule

// File: tb/test_trap_ctl_top.sv
module test_trap_ctl_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic [31:0] pc = 0;
    logic [5:0]  opcode = 0;
    logic        irq = 0;
    logic [63:0] impl_mask = '1;
    logic [2:0]  dec_pc_sel = 0;
    logic [1:0]  dec_wd_sel = 1;
    logic [4:0]  dec_waddr = 0;
    logic        dec_rf_we = 0, dec_mem_we = 0;
    logic [2:0]  pc_sel;
    logic [31:0] vec_addr, ret_addr;
    logic [1:0]  rf_wd_sel;
    logic [4:0]  rf_waddr;
    logic        rf_we, mem_we, trap_taken;

    int checks = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_ctl_top i_trap_ctl_top (
        .clk, .rst, .pc, .opcode, .irq, .impl_mask, .dec_pc_sel, .dec_wd_sel,
        .dec_waddr, .dec_rf_we, .dec_mem_we, .pc_sel, .vec_addr, .ret_addr,
        .rf_wd_sel, .rf_waddr, .rf_we, .mem_we, .trap_taken
    );

    task automatic cmp(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 reset, 1 illegal, 2 irq, 3 none
    task automatic compare_now();
        int kind;
        string tag;
        logic [31:0] e_vec, e_ret;
        logic [2:0] e_ps; logic [1:0] e_wd; logic [4:0] e_wa; logic e_we, e_mw;
        if (rst) kind = 0;
        else if (impl_mask[opcode] == 0) kind = 1;
        else if (irq && pc[31] == 0) kind = 2;
        else kind = 3;
        tag = (kind == 0) ? "R1" : (kind == 1) ? ((irq && !pc[31]) ? "R5" : "R2")
            : (kind == 2) ? "R3" : ((irq && pc[31]) ? "R4" : "R7");
        if (kind == 3) begin
            e_vec = 0; e_ps = dec_pc_sel; e_wd = dec_wd_sel; e_wa = dec_waddr;
            e_we = dec_rf_we && dec_waddr != 31; e_mw = dec_mem_we;
        end else begin
            e_vec = 32'h8000_0000 + kind * 4; e_ps = 4; e_wd = 0; e_wa = 30;
            e_we = (kind != 0); e_mw = 0;
        end
        e_ret = {pc[31], 31'(pc[30:0] + 31'd4)};
        cmp(tag, "trap_taken", trap_taken, kind != 3);
        cmp(tag, "pc_sel", pc_sel, e_ps);
        cmp(tag, "vec_addr", vec_addr, e_vec);
        if (kind == 3 || kind == 0) cmp(tag, "rf_wd_sel", rf_wd_sel, e_wd);
        else cmp(tag, "rf_wd_sel", rf_wd_sel, e_wd);
        if (kind != 0) cmp(tag, "rf_waddr", rf_waddr, e_wa);
        cmp((kind == 3 && dec_waddr == 31) ? "R9" : tag, "rf_we", rf_we, e_we);
        cmp((kind == 3) ? "R7" : "R8", "mem_we", mem_we, e_mw);
        cmp("R6", "ret_addr", ret_addr, e_ret);
        if (kind != 3) cmp("R10", "vec_bit31", vec_addr[31], 1);
    endtask

    task automatic step(logic r, logic [31:0] p, logic [5:0] op, logic iq,
                        logic [63:0] m, logic [4:0] wa, logic we, logic mw);
        rst = r; pc = p; opcode = op; irq = iq; impl_mask = m;
        dec_pc_sel = 3'd1; dec_wd_sel = 2'd1; dec_waddr = wa; dec_rf_we = we; dec_mem_we = mw;
        @(negedge clk);
        compare_now();
    endtask

    initial begin
        logic [63:0] m3 = ~64'h6; // opcodes 1 and 2 unimplemented
        // R1: reset with a store, irq and illegal opcode present
        step(1, 32'h0000_0100, 6'd1, 1, m3, 5'd3, 1, 1);
        step(1, 32'h8000_0040, 6'd20, 0, '1, 5'd30, 1, 0);
        // R7: plain pass-through
        step(0, 32'h0000_0200, 6'd20, 0, m3, 5'd7, 1, 1);
        // R2: supervisor call opcode in user mode and opcode 2 in supervisor mode
        step(0, 32'h0000_0300, 6'd1, 0, m3, 5'd4, 1, 1);
        step(0, 32'h8000_0300, 6'd2, 0, m3, 5'd4, 0, 0);
        // R3: user-mode interrupt aborting a store
        step(0, 32'h0000_0400, 6'd20, 1, m3, 5'd9, 0, 1);
        // R4: supervisor-mode interrupt ignored
        step(0, 32'h8000_0400, 6'd20, 1, m3, 5'd9, 1, 1);
        // R5: illegal opcode and irq together
        step(0, 32'h0000_0500, 6'd2, 1, m3, 5'd5, 1, 1);
        // R9: decoder asks to write register 31
        step(0, 32'h0000_0600, 6'd20, 0, m3, 5'd31, 1, 0);
        // R6: wrap of the low 31 bits in both modes
        step(0, 32'h7FFF_FFFC, 6'd20, 1, m3, 5'd1, 1, 0);
        step(0, 32'hFFFF_FFFC, 6'd20, 1, m3, 5'd1, 1, 0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] p;
            p = $urandom;
            if (i % 17 == 0) p = {p[31], 31'h7FFF_FFFC};
            step(($urandom % 16) == 0, p, 6'($urandom), 1'($urandom),
                 {$urandom, $urandom} | {$urandom, $urandom},
                 ($urandom % 4 == 0) ? 5'd31 : 5'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule